// File: doc/BRIEF.md
# Split Completion Reassembly Buffer

This block sits on the receive side of a requester that issues non-posted read requests, each identified by a tag. A read may be answered by several split completion packets. The block writes each split into a storage slot reserved for its tag. When the final split of a request has arrived, it sends the whole request downstream as one contiguous 32-bit beat stream. A memory-mapped consumer therefore never sees a partial answer, and requests that finish out of issue order are delivered in the order they finish.

Each request is registered first through the allocation port, which gives its tag, its starting byte address (the low address bits only) and its length in 32-bit words. A completion packet carries its header on its first beat and one data word on every beat. The header holds the tag, the remaining byte count, the lower address and the payload length in words. Completions are always accepted, so the block has no back-pressure on that side. Each tag's slot holds the largest request, so storage covers every outstanding request at full size. All addresses and lengths are whole 32-bit words. `MAX_BYTES` and `NUM_TAGS` must be powers of two.

Top module: `scr_reassembly_buf`

## Requirements
- R1: While reset is asserted and directly after it is released, `rsp_valid_o` is 0.
- R2: Every data beat of a split is stored at word offset ((lower address - request start address) mod 2^LA_W) / 4 plus the beat index within the split. The merged response returns word k of the request as its k-th beat, including when the lower address wraps past 2^LA_W.
- R3: A request is complete only when a split arrives whose remaining byte count equals 4 times that split's payload length in words. Splits that do not satisfy this never make `rsp_valid_o` rise.
- R4: Each allocated request produces exactly one response of exactly its allocated number of words. `rsp_last_o` is 1 on the final beat only.
- R5: Completed requests are emitted in the order their final splits were accepted, regardless of tag value or allocation order.
- R6: While `rsp_valid_o` is 1 and `rsp_ready_i` is 0, `rsp_valid_o`, `rsp_tag_o`, `rsp_data_o` and `rsp_last_o` stay unchanged.
- R7: A tag is released on the clock edge that accepts its last output beat. It may then be allocated again and returns only the new data. Allocation targets only released tags, and completions target only allocated tags.
- R8: The final split of one request may be accepted on the same edge as the last output beat of another request, together with an allocation of a third tag. None of these events is lost.
- R9: With no other completed request waiting, `rsp_valid_o` is 1 in the cycle right after the edge that accepts the last beat of the final split.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Register a new request |
| alloc_tag_i | input | TAG_W | Tag of the new request |
| alloc_start_i | input | LA_W | Low byte address of the request start |
| alloc_words_i | input | LEN_W | Request length in 32-bit words (1 to MAX_BYTES/4) |
| cpl_valid_i | input | 1 | Completion beat present |
| cpl_sop_i | input | 1 | First beat of a split; header fields valid |
| cpl_tag_i | input | TAG_W | Tag of the split |
| cpl_bc_i | input | BC_W | Bytes remaining in the request from this split on |
| cpl_la_i | input | LA_W | Lower byte address of the split |
| cpl_len_i | input | LEN_W | Split payload length in words |
| cpl_data_i | input | 32 | Payload word |
| rsp_ready_i | input | 1 | Consumer accepts the current beat |
| rsp_valid_o | output | 1 | Merged response beat present |
| rsp_tag_o | output | TAG_W | Tag of the response |
| rsp_data_o | output | 32 | Response word |
| rsp_last_o | output | 1 | Final beat of the response |

## Verification
Two functions can act on the same clock edge. One is the completion side, which queues a newly finished tag. The other is the output side, which pops the queue head and releases its tag on the last beat. To force them together, the bench holds ready high, waits until the last beat of a long response is on the port, and presents a one-word final split of another tag on that same cycle, along with an allocation of a third tag. The verdict comes from the next cycle: the new tag must be at the head with its data, and the allocated tag must later return its own data. Near-exhaustive sweeps over all tags, with varying lengths, start addresses and split sizes and random stalls, cover ordering, placement and the hold rule.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int BEAT_W     = 32;
  localparam int BEAT_BYTES = BEAT_W / 8;
endpackage

// File: rtl/scr_tag_table.sv
module scr_tag_table #(
  parameter int NUM_TAGS = 8,
  parameter int TAG_W    = 3,
  parameter int LA_W     = 7,
  parameter int LEN_W    = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                alloc_valid_i,
  input  logic [TAG_W-1:0]    alloc_tag_i,
  input  logic [LA_W-1:0]     alloc_start_i,
  input  logic [LEN_W-1:0]    alloc_words_i,
  input  logic                free_valid_i,
  input  logic [TAG_W-1:0]    free_tag_i,
  input  logic [TAG_W-1:0]    cpl_tag_i,
  output logic [LA_W-1:0]     start_o,
  input  logic [TAG_W-1:0]    out_tag_i,
  output logic [LEN_W-1:0]    words_o,
  output logic [NUM_TAGS-1:0] busy_o
);
  logic [LA_W-1:0]  start_q [NUM_TAGS];
  logic [LEN_W-1:0] words_q [NUM_TAGS];

  for (genvar g = 0; g < NUM_TAGS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        busy_o[g]  <= 1'b0;
        start_q[g] <= '0;
        words_q[g] <= '0;
      end else if (alloc_valid_i && alloc_tag_i == TAG_W'(g)) begin
        busy_o[g]  <= 1'b1;
        start_q[g] <= alloc_start_i;
        words_q[g] <= alloc_words_i;
      end else if (free_valid_i && free_tag_i == TAG_W'(g)) begin
        busy_o[g]  <= 1'b0;
      end
    end
  end

  assign start_o = start_q[cpl_tag_i];
  assign words_o = words_q[out_tag_i];

  assert_alloc_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_valid_i |-> !busy_o[alloc_tag_i]);
endmodule

// File: rtl/scr_rx.sv
module scr_rx #(
  parameter int TAG_W  = 3,
  parameter int LA_W   = 7,
  parameter int BC_W   = 7,
  parameter int LEN_W  = 5,
  parameter int WOFF_W = 4,
  parameter int WPT    = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cpl_valid_i,
  input  logic                    cpl_sop_i,
  input  logic [TAG_W-1:0]        cpl_tag_i,
  input  logic [BC_W-1:0]         cpl_bc_i,
  input  logic [LA_W-1:0]         cpl_la_i,
  input  logic [LEN_W-1:0]        cpl_len_i,
  input  logic [scr_pkg::BEAT_W-1:0] cpl_data_i,
  input  logic [LA_W-1:0]         start_i,
  output logic                    wr_en_o,
  output logic [TAG_W+WOFF_W-1:0] wr_addr_o,
  output logic [scr_pkg::BEAT_W-1:0] wr_data_o,
  output logic                    done_o,
  output logic [TAG_W-1:0]        done_tag_o
);
  logic [TAG_W-1:0]  tag_q, cur_tag;
  logic [WOFF_W-1:0] off_q, cur_off, hdr_off;
  logic [LEN_W-1:0]  left_q, cur_left;
  logic              fin_q, cur_fin, hdr_fin;
  logic [LA_W-1:0]   diff;
  logic              unused_diff;

  // byte distance from request start, modulo the address field width
  assign diff        = cpl_la_i - start_i;
  assign hdr_off     = diff[2 +: WOFF_W];
  assign unused_diff = ^{diff[1:0], diff[LA_W-1:WOFF_W+2]};
  assign hdr_fin     = (cpl_bc_i == {cpl_len_i, 2'b00});

  always_comb begin
    if (cpl_sop_i) begin
      cur_tag  = cpl_tag_i;
      cur_off  = hdr_off;
      cur_left = cpl_len_i;
      cur_fin  = hdr_fin;
    end else begin
      cur_tag  = tag_q;
      cur_off  = off_q;
      cur_left = left_q;
      cur_fin  = fin_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q  <= '0;
      off_q  <= '0;
      left_q <= '0;
      fin_q  <= 1'b0;
    end else if (cpl_valid_i) begin
      tag_q  <= cur_tag;
      off_q  <= cur_off + WOFF_W'(1);
      left_q <= cur_left - LEN_W'(1);
      fin_q  <= cur_fin;
    end
  end

  assign wr_en_o    = cpl_valid_i;
  assign wr_addr_o  = {cur_tag, cur_off};
  assign wr_data_o  = cpl_data_i;
  assign done_o     = cpl_valid_i && cur_fin && (cur_left == LEN_W'(1));
  assign done_tag_o = cur_tag;

  assert_split_fits_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpl_valid_i && cpl_sop_i |-> (cpl_len_i != '0) && (int'(hdr_off) + int'(cpl_len_i) <= WPT));
  assert_beats_contiguous_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    left_q != '0 |-> cpl_valid_i && !cpl_sop_i);
endmodule

// File: rtl/scr_data_store.sv
module scr_data_store #(
  parameter int DEPTH = 128,
  parameter int AW    = 7
) (
  input  logic                       clk_i,
  input  logic                       wr_en_i,
  input  logic [AW-1:0]              wr_addr_i,
  input  logic [scr_pkg::BEAT_W-1:0] wr_data_i,
  input  logic [AW-1:0]              rd_addr_i,
  output logic [scr_pkg::BEAT_W-1:0] rd_data_o
);
  logic [scr_pkg::BEAT_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
  end

  assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/scr_done_fifo.sv
module scr_done_fifo #(
  parameter int NUM_TAGS = 8,
  parameter int TAG_W    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [TAG_W-1:0] push_tag_i,
  input  logic             pop_i,
  output logic             empty_o,
  output logic [TAG_W-1:0] head_o
);
  localparam int CNT_W = $clog2(NUM_TAGS + 1);

  logic [TAG_W-1:0] slot_q [NUM_TAGS];
  logic [TAG_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full;

  assign empty_o = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(NUM_TAGS));
  assign head_o  = slot_q[rp_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < NUM_TAGS; i++) slot_q[i] <= '0;
    end else begin
      if (push_i) begin
        slot_q[wp_q] <= push_tag_i;
        wp_q         <= wp_q + TAG_W'(1);
      end
      if (pop_i) rp_q <= rp_q + TAG_W'(1);
      cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full || pop_i);
  assert_no_underflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/scr_reassembly_buf.sv
module scr_reassembly_buf #(
  parameter  int NUM_TAGS  = 8,
  parameter  int MAX_BYTES = 64,
  localparam int TAG_W     = $clog2(NUM_TAGS),
  localparam int WPT       = MAX_BYTES / scr_pkg::BEAT_BYTES,
  localparam int WOFF_W    = $clog2(WPT),
  localparam int LEN_W     = WOFF_W + 1,
  localparam int BC_W      = $clog2(MAX_BYTES) + 1,
  localparam int LA_W      = BC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_valid_i,
  input  logic [TAG_W-1:0] alloc_tag_i,
  input  logic [LA_W-1:0]  alloc_start_i,
  input  logic [LEN_W-1:0] alloc_words_i,
  input  logic             cpl_valid_i,
  input  logic             cpl_sop_i,
  input  logic [TAG_W-1:0] cpl_tag_i,
  input  logic [BC_W-1:0]  cpl_bc_i,
  input  logic [LA_W-1:0]  cpl_la_i,
  input  logic [LEN_W-1:0] cpl_len_i,
  input  logic [31:0]      cpl_data_i,
  input  logic             rsp_ready_i,
  output logic             rsp_valid_o,
  output logic [TAG_W-1:0] rsp_tag_o,
  output logic [31:0]      rsp_data_o,
  output logic             rsp_last_o
);
  localparam int AW = TAG_W + WOFF_W;

  logic [LA_W-1:0]     start_w;
  logic [LEN_W-1:0]    out_words;
  logic [NUM_TAGS-1:0] busy;
  logic                wr_en, done, fifo_empty, fire, pop;
  logic [AW-1:0]       wr_addr;
  logic [31:0]         wr_data;
  logic [TAG_W-1:0]    done_tag, head_tag;
  logic [WOFF_W-1:0]   idx_q;

  scr_tag_table #(.NUM_TAGS(NUM_TAGS), .TAG_W(TAG_W), .LA_W(LA_W), .LEN_W(LEN_W)) u_tags (
    .clk_i, .rst_ni,
    .alloc_valid_i, .alloc_tag_i, .alloc_start_i, .alloc_words_i,
    .free_valid_i(pop), .free_tag_i(head_tag),
    .cpl_tag_i, .start_o(start_w),
    .out_tag_i(head_tag), .words_o(out_words),
    .busy_o(busy)
  );

  scr_rx #(.TAG_W(TAG_W), .LA_W(LA_W), .BC_W(BC_W), .LEN_W(LEN_W),
           .WOFF_W(WOFF_W), .WPT(WPT)) u_rx (
    .clk_i, .rst_ni,
    .cpl_valid_i, .cpl_sop_i, .cpl_tag_i, .cpl_bc_i, .cpl_la_i, .cpl_len_i, .cpl_data_i,
    .start_i(start_w),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .done_o(done), .done_tag_o(done_tag)
  );

  scr_data_store #(.DEPTH(NUM_TAGS * WPT), .AW(AW)) u_store (
    .clk_i,
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i({head_tag, idx_q}), .rd_data_o(rsp_data_o)
  );

  scr_done_fifo #(.NUM_TAGS(NUM_TAGS), .TAG_W(TAG_W)) u_done (
    .clk_i, .rst_ni,
    .push_i(done), .push_tag_i(done_tag),
    .pop_i(pop), .empty_o(fifo_empty), .head_o(head_tag)
  );

  // output streams straight from the head of the completion-order queue
  assign rsp_valid_o = !fifo_empty;
  assign rsp_tag_o   = head_tag;
  assign rsp_last_o  = ({1'b0, idx_q} == out_words - LEN_W'(1));
  assign fire        = rsp_valid_o && rsp_ready_i;
  assign pop         = fire && rsp_last_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   idx_q <= '0;
    else if (fire) idx_q <= rsp_last_o ? '0 : idx_q + WOFF_W'(1);
  end

  assert_rsp_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_tag_o)
                                    && $stable(rsp_data_o) && $stable(rsp_last_o));
  assert_cpl_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpl_valid_i && cpl_sop_i |-> busy[cpl_tag_i]);
  assert_rsp_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> busy[rsp_tag_o]);
endmodule

// File: tb/tb_scr_reassembly_buf.sv
module tb_scr_reassembly_buf;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       alloc_valid = 1'b0;
  logic [2:0] alloc_tag = '0;
  logic [6:0] alloc_start = '0;
  logic [4:0] alloc_words = '0;
  logic       cpl_valid = 1'b0, cpl_sop = 1'b0;
  logic [2:0] cpl_tag = '0;
  logic [6:0] cpl_bc = '0, cpl_la = '0;
  logic [4:0] cpl_len = '0;
  logic [31:0] cpl_data = '0;
  logic       rsp_ready = 1'b0;
  logic       rsp_valid, rsp_last;
  logic [2:0] rsp_tag;
  logic [31:0] rsp_data;

  always #10 clk = ~clk;  // 50 MHz

  scr_reassembly_buf dut (
    .clk_i(clk), .rst_ni(rst_n),
    .alloc_valid_i(alloc_valid), .alloc_tag_i(alloc_tag),
    .alloc_start_i(alloc_start), .alloc_words_i(alloc_words),
    .cpl_valid_i(cpl_valid), .cpl_sop_i(cpl_sop), .cpl_tag_i(cpl_tag),
    .cpl_bc_i(cpl_bc), .cpl_la_i(cpl_la), .cpl_len_i(cpl_len), .cpl_data_i(cpl_data),
    .rsp_ready_i(rsp_ready), .rsp_valid_o(rsp_valid), .rsp_tag_o(rsp_tag),
    .rsp_data_o(rsp_data), .rsp_last_o(rsp_last)
  );

  int n_tests = 0, n_fail = 0;
  int exp_q[$];
  logic [31:0] exp_mem [8][16];
  int exp_len [8];
  int exp_start [8];
  int offs [8];
  int sent_cnt = 0, resp_cnt = 0, beat_idx = 0, cyc = 0;
  bit force_rdy = 1'b0, mon_on = 1'b0, more;
  bit hold_p = 1'b0;
  logic [2:0] p_tag; logic [31:0] p_data; logic p_last;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor owns rsp_ready; outputs only change at posedge, so negedge sampling is race-free
  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      bit rdy;
      if (hold_p) begin  // R6
        chk(rsp_valid && rsp_tag == p_tag && rsp_data == p_data && rsp_last == p_last,
            "R6", "held beat changed", {rsp_valid, rsp_last, 27'd0, rsp_tag}, {1'b1, p_last, 27'd0, p_tag});
      end
      rdy = force_rdy ? 1'b1 : lfsr[0];
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rsp_ready = rdy;
      if (rsp_valid && rdy) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4", "unexpected response tag", 32'(rsp_tag), 32'hFFFF_FFFF);
        end else begin
          int t;
          t = exp_q[0];
          chk(rsp_tag == 3'(t), "R5", "response order tag", 32'(rsp_tag), 32'(t));
          chk(rsp_data == exp_mem[t][beat_idx], "R2", "merged word", rsp_data, exp_mem[t][beat_idx]);
          chk(rsp_last == (beat_idx == exp_len[t] - 1), "R4", "last marker",
              32'(rsp_last), 32'(beat_idx == exp_len[t] - 1));
          if (rsp_last || beat_idx == exp_len[t] - 1) begin
            void'(exp_q.pop_front());
            beat_idx = 0;
            resp_cnt++;
          end else beat_idx++;
        end
      end
      hold_p = rsp_valid && !rdy;
      p_tag = rsp_tag; p_data = rsp_data; p_last = rsp_last;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic set_exp(input int t, input int start, input int words, input int seed);
    exp_start[t] = start;
    exp_len[t] = words;
    for (int w = 0; w < 16; w++)
      exp_mem[t][w] = {8'(seed) ^ 8'h5A, 8'(t), 8'(w), 8'(seed * t + w * 7)};
  endtask

  task automatic do_alloc(input int t, input int start, input int words, input int seed);
    @(negedge clk);
    alloc_valid = 1'b1; alloc_tag = 3'(t); alloc_start = 7'(start); alloc_words = 5'(words);
    set_exp(t, start, words, seed);
    @(negedge clk);
    alloc_valid = 1'b0;
  endtask

  task automatic send_split(input int t, input int off, input int nw, input bit sync);
    for (int k = 0; k < nw; k++) begin
      if (k > 0 || sync) @(negedge clk);
      cpl_valid = 1'b1; cpl_sop = (k == 0); cpl_tag = 3'(t);
      cpl_bc = 7'((exp_len[t] - off) * 4);
      cpl_la = 7'(exp_start[t] + off * 4);
      cpl_len = 5'(nw);
      cpl_data = exp_mem[t][off + k];
      if (k == nw - 1 && off + nw == exp_len[t]) begin
        exp_q.push_back(t);
        sent_cnt++;
      end
    end
    @(negedge clk);
    cpl_valid = 1'b0; cpl_sop = 1'b0;
  endtask

  task automatic wait_drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1'b0, "R1", "valid in reset", 32'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1", "valid after reset", 32'(rsp_valid), 0);
    mon_on = 1'b1;

    // R3: partial splits never raise valid; R9: final split gives valid next cycle
    do_alloc(5, 8, 6, 99);
    send_split(5, 0, 2, 1);
    send_split(5, 2, 2, 1);
    repeat (4) begin
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R3", "valid before final split", 32'(rsp_valid), 0);
    end
    send_split(5, 4, 2, 1);
    chk(rsp_valid == 1'b1 && rsp_tag == 3'd5, "R9", "valid one cycle after final beat",
        {31'd0, rsp_valid}, 1);
    wait_drain();

    // near-exhaustive sweep: all tags, varied lengths, starts (with wrap), split sizes
    for (int r = 0; r < 12; r++) begin
      for (int t = 0; t < 8; t++)
        do_alloc(t, ((t * 44 + r * 28) % 128) & ~3, 1 + ((t * 7 + r * 5) % 16), r);
      for (int t = 0; t < 8; t++) offs[t] = 0;
      more = 1'b1;
      while (more) begin
        more = 1'b0;
        for (int i = 0; i < 8; i++) begin
          int t, nw;
          t = (r % 2 == 1) ? 7 - i : i;
          if (offs[t] < exp_len[t]) begin
            nw = 1 + ((t * 3 + r + offs[t]) % 4);
            if (nw > exp_len[t] - offs[t]) nw = exp_len[t] - offs[t];
            send_split(t, offs[t], nw, 1);
            offs[t] += nw;
            more = 1'b1;
          end
        end
      end
      wait_drain();
      // R7: every tag reused each round; all released and idle
      chk(rsp_valid == 1'b0, "R7", "idle after round", 32'(rsp_valid), 0);
    end

    // R8: final split of tag 6 and alloc of tag 7 on the edge of tag 2's last beat
    force_rdy = 1'b1;
    do_alloc(2, 124, 16, 33);   // start near top: offsets wrap (R2)
    do_alloc(6, 16, 1, 34);
    send_split(2, 0, 5, 1);
    send_split(2, 5, 5, 1);
    send_split(2, 10, 6, 1);
    while (!(rsp_valid && rsp_last && rsp_tag == 3'd2)) @(negedge clk);
    alloc_valid = 1'b1; alloc_tag = 3'd7; alloc_start = 7'd40; alloc_words = 5'd3;
    set_exp(7, 40, 3, 35);
    send_split(6, 0, 1, 0);
    alloc_valid = 1'b0;
    chk(rsp_valid == 1'b1 && rsp_tag == 3'd6, "R8", "same-edge finish and release",
        {28'd0, rsp_valid, rsp_tag}, {28'd0, 1'b1, 3'd6});
    send_split(7, 0, 2, 1);
    send_split(7, 2, 1, 1);
    wait_drain();
    force_rdy = 1'b0;

    // R7: released tag reallocated returns only new data
    do_alloc(2, 0, 2, 77);
    send_split(2, 0, 2, 1);
    wait_drain();

    chk(resp_cnt == sent_cnt, "R4", "one response per request", 32'(resp_cnt), 32'(sent_cnt));
    chk(rsp_valid == 1'b0, "R4", "no extra response", 32'(rsp_valid), 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule